// File: doc/BRIEF.md
# Half to Single Precision Float Widener

This block turns a 16-bit IEEE-754 half-precision bit pattern into the 32-bit single-precision pattern that holds the same value. Every half value can be written exactly in single precision, so the block never rounds. Zeros and infinities keep their sign. Normal numbers have their exponent rebiased. Subnormal halves are renormalised using a leading-zero count of their fraction.

NaN inputs take one of two paths, chosen by a mode input. With default-NaN mode on, every NaN becomes one fixed quiet pattern. With the mode off, the NaN keeps its sign and its payload and is made quiet. A signalling NaN raises an invalid-operation flag in both modes. The flag belongs to each conversion alone and does not hold its value.

The parameter `REG_OUT` picks one of two forms. With a value of 1, which is the default, the result and flag come from a register and appear one clock after the input. With a value of 0, the path from input to output is purely combinational.

Top module: `hfp_widen`

## Requirements
- R1: A half input with exponent field (bits 14:10) from 1 to 30 gives a result whose fraction (bits 22:0) is the 10-bit input fraction followed by 13 zero bits, whose exponent (bits 30:23) is the input exponent plus 112, and whose sign (bit 31) equals input bit 15.
- R2: A half input with exponent field 0 and a nonzero fraction is renormalised. Let c be the number of leading zeros in the 10-bit fraction. The result exponent is 112 - c. The result fraction is the input fraction shifted left by 14 + c and cut to 23 bits. The sign is kept. For example, 0x0001 gives 0x33800000.
- R3: A half zero (exponent 0, fraction 0) gives 0x00000000 for sign 0 and 0x80000000 for sign 1.
- R4: A half infinity (exponent 31, fraction 0) gives 0x7F800000 for sign 0 and 0xFF800000 for sign 1.
- R5: With `dnan_mode` high, every NaN input (exponent 31, nonzero fraction) gives 0x7FC00000, whatever its sign and payload.
- R6: With `dnan_mode` low, a NaN input gives a result with the input sign, exponent 255, and fraction equal to the input fraction shifted left by 13, with bit 22 forced to 1.
- R7: `inv_flag` is high exactly when the input is a signalling NaN, meaning exponent 31, bit 9 clear, and a nonzero fraction. This holds in both `dnan_mode` settings. For every other input the flag is low.
- R8: With `REG_OUT`=1, the result and flag for an input sampled at a rising clock edge appear after that edge, and an active-low reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_in | input | 16 | Half-precision input pattern |
| dnan_mode | input | 1 | When high, NaN results are replaced by the default NaN |
| single_out | output | 32 | Single-precision result pattern |
| inv_flag | output | 1 | Invalid-operation flag, raised for a signalling NaN input |

## Verification
The checker assumes that `half_in` and `dnan_mode` are stable around each sampling clock edge. It also assumes that each output value belongs to the input seen one edge earlier. To line the two up, it keeps its own delayed copy of the inputs and does not check until the first edge after reset. The bench changes the inputs only on falling edges, one pattern per cycle. It steps through every 16-bit pattern in both mode settings, so every class and every subnormal shift amount is covered.

// File: rtl/hfp_widen.sv
module hfp_widen #(
  parameter int REG_OUT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] half_in,
  input  logic        dnan_mode,
  output logic [31:0] single_out,
  output logic        inv_flag
);

  localparam int HEXP_W  = 5;
  localparam int HFRAC_W = 10;
  localparam int SFRAC_W = 23;
  localparam int SEXP_W  = 8;
  localparam int FRAC_GAP = SFRAC_W - HFRAC_W;
  localparam int REBIAS   = 127 - 15;
  localparam logic [31:0] DEFAULT_NAN = 32'h7FC0_0000;

  function automatic logic [3:0] lead_zeros(input logic [HFRAC_W-1:0] f);
    logic [3:0] n;
    n = 4'(HFRAC_W);
    for (int i = 0; i < HFRAC_W; i++)
      if (f[i]) n = 4'(HFRAC_W - 1 - i);
    return n;
  endfunction

  logic                 sgn;
  logic [HEXP_W-1:0]    hexp;
  logic [HFRAC_W-1:0]   hfrac;
  logic                 exp_zero, exp_ones, frac_zero;
  logic                 is_zero, is_sub, is_inf, is_nan, is_snan;
  logic [3:0]           lz;
  logic [SFRAC_W+HFRAC_W-1:0] sub_shift;
  logic [31:0]          res_c;

  assign sgn       = half_in[15];
  assign hexp      = half_in[14:10];
  assign hfrac     = half_in[9:0];
  assign exp_zero  = (hexp == '0);
  assign exp_ones  = (hexp == '1);
  assign frac_zero = (hfrac == '0);
  assign is_zero   = exp_zero & frac_zero;
  assign is_sub    = exp_zero & ~frac_zero;
  assign is_inf    = exp_ones & frac_zero;
  assign is_nan    = exp_ones & ~frac_zero;
  assign is_snan   = is_nan & ~hfrac[HFRAC_W-1];

  assign lz        = lead_zeros(hfrac);
  assign sub_shift = {{SFRAC_W{1'b0}}, hfrac} << (FRAC_GAP + 1 + int'(lz));

  always_comb begin
    if (is_zero)
      res_c = {sgn, 31'b0};
    else if (is_inf)
      res_c = {sgn, {SEXP_W{1'b1}}, {SFRAC_W{1'b0}}};
    else if (is_nan)
      res_c = dnan_mode ? DEFAULT_NAN
                        : {sgn, {SEXP_W{1'b1}}, 1'b1, hfrac[HFRAC_W-2:0], {FRAC_GAP{1'b0}}};
    else if (is_sub)
      res_c = {sgn, SEXP_W'(REBIAS - int'(lz)), sub_shift[SFRAC_W-1:0]};
    else
      res_c = {sgn, SEXP_W'(int'(hexp) + REBIAS), hfrac, {FRAC_GAP{1'b0}}};
  end

  generate
    if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          single_out <= '0;
          inv_flag   <= 1'b0;
        end else begin
          single_out <= res_c;
          inv_flag   <= is_snan;
        end
      end
    end else begin : g_comb
      assign single_out = res_c;
      assign inv_flag   = is_snan;
    end
  endgenerate

endmodule

module hfp_widen_chk #(
  parameter int LAT = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] half_in,
  input logic        dnan_mode,
  input logic [31:0] single_out,
  input logic        inv_flag
);

  logic [15:0] h;
  logic        dn;
  logic        armed;

  generate
    if (LAT != 0) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          h <= '0; dn <= 1'b0; armed <= 1'b0;
        end else begin
          h <= half_in; dn <= dnan_mode; armed <= 1'b1;
        end
      end
    end else begin : g_now
      assign h = half_in;
      assign dn = dnan_mode;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) armed <= 1'b0; else armed <= 1'b1;
    end
  endgenerate

  logic h_nan, h_zero, h_fin;
  assign h_nan  = (h[14:10] == 5'h1F) && (h[9:0] != 0);
  assign h_zero = (h[14:0] == 0);
  assign h_fin  = (h[14:10] != 5'h1F) && !h_zero;

  a_r7_flag_only_snan: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && inv_flag) |-> (h_nan && !h[9]));
  a_r7_flag_on_snan: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && h_nan && !h[9]) |-> inv_flag);
  a_r5_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && h_nan && dn) |-> (single_out == 32'h7FC0_0000));
  a_r6_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && h_nan) |-> (single_out[30:22] == 9'h1FF));
  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && h_zero) |-> (single_out[30:0] == 0 && single_out[31] == h[15]));
  a_r1_finite_range: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && h_fin) |-> (single_out[30:23] >= 8'd103 && single_out[30:23] <= 8'd142
                          && single_out[31] == h[15]));
  a_r8_reset_clear: assert property (@(posedge clk)
    (!rst_n) |-> (LAT == 0 || (single_out == 0 && !inv_flag)));

endmodule

bind hfp_widen hfp_widen_chk #(.LAT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_in(half_in), .dnan_mode(dnan_mode),
  .single_out(single_out), .inv_flag(inv_flag)
);

// File: tb/sim_hfp_widen.sv
module sim_hfp_widen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] half_in = '0;
  logic        dnan_mode = 1'b0;
  logic [31:0] single_out;
  logic        inv_flag;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit drv_done = 0;

  typedef struct { logic [15:0] h; logic dn; logic [31:0] res; logic flg; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  hfp_widen #(.REG_OUT(1)) u0 (
    .clk(clk), .rst_n(rst_n), .half_in(half_in), .dnan_mode(dnan_mode),
    .single_out(single_out), .inv_flag(inv_flag)
  );

  function automatic item_t model(logic [15:0] h, logic dn);
    item_t it;
    int e;
    logic [10:0] m;
    it.h = h; it.dn = dn; it.flg = 1'b0;
    if (h[14:10] == 5'd31) begin
      if (h[9:0] == 0) it.res = h[15] ? 32'hFF80_0000 : 32'h7F80_0000;
      else begin
        it.flg = ~h[9];
        it.res = dn ? 32'h7FC0_0000 : {h[15], 8'hFF, 23'(h[9:0]) << 13};
        it.res[22] = 1'b1;
      end
    end else if (h[14:10] == 0) begin
      if (h[9:0] == 0) it.res = {h[15], 31'b0};
      else begin
        e = 127 - 14;
        m = {1'b0, h[9:0]};
        while (!m[10]) begin m = m << 1; e--; end
        it.res = {h[15], 8'(e), m[9:0], 13'b0};
      end
    end else
      it.res = {h[15], 8'(int'(h[14:10]) - 15 + 127), h[9:0], 13'b0};
    return it;
  endfunction

  function automatic string tag_of(item_t it);
    if (it.h[14:10] == 5'd31) return (it.h[9:0] == 0) ? "R4" : (it.dn ? "R5/R7" : "R6/R7");
    if (it.h[14:10] == 0) return (it.h[9:0] == 0) ? "R3" : "R2";
    return "R1";
  endfunction

  task automatic drive(logic [15:0] h, logic dn);
    @(negedge clk);
    half_in = h; dnan_mode = dn;
    sb.push_back(model(h, dn));
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (rst_n && sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (single_out !== it.res || inv_flag !== it.flg) begin
          fails++;
          $display("FAIL %s in=%h dn=%0d got=%h/%0d exp=%h/%0d", tag_of(it), it.h, it.dn,
                   single_out, inv_flag, it.res, it.flg);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    half_in = 16'h7C01; dnan_mode = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (single_out !== 32'h0 || inv_flag !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset got=%h/%0d exp=00000000/0", single_out, inv_flag);
    end
    @(negedge clk); rst_n = 1'b1;
    // R8 latency: each pattern is checked one edge after it is sampled
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 65536; v++)
        drive(16'(v), m[0]);
    drv_done = 1;
    repeat (4) @(posedge clk);
    if (sb.size() != 0) begin
      fails++; checks++;
      $display("FAIL R8 leftover got=%0d exp=0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule